// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block watches a group of external interrupt pins (eight by default) and turns each one into an active-high level request for a parent interrupt controller. Every pin first passes through a synchronizer. A two-bit sense field per pin then selects what the pin means. In level-low mode the request simply follows the inverted pin. In the falling, rising and both-edge modes a qualifying transition sets a sticky pending bit, and that bit stays set until software clears it.

Software reaches the block through a plain single-cycle register port with valid, write, address and 32-bit data signals. The port exposes three registers: a sense-select register, a pending-status register and a mask register. Read data is combinational, so a read issued in the cycle after a clear write already shows the cleared bit. A set mask bit holds back that pin's request but leaves its status bit untouched.

Top module: `ext_irq_sense_top`

## Requirements
- R1: After reset the sense register, the status register and the mask register all read 0, and with the pins held high every request output is low.
- R2: The sense register sits at offset 0x14. Line n uses bits [2n+1:2n], with code 0 for level-low, 1 for falling edge, 2 for rising edge and 3 for both edges. The bits above the used fields always read 0.
- R3: In an edge mode, a transition of the pin that matches the line's code sets the line's status bit. The bit can be read three clock cycles after the pin changes. A transition that does not match the code leaves the bit at 0.
- R4: In level-low mode, the line's status bit reads as the inverse of the synchronized pin, two cycles after the pin changes. The bit is not stored, and a clear write to it has no effect.
- R5: The status register sits at offset 0x10. In an edge mode, writing 0 to bit n clears the bit, and writing 1 leaves it unchanged. A read in the cycle right after the write already shows the cleared value.
- R6: If a matching edge is detected in the same cycle that a clear write reaches the line, the status bit stays set.
- R7: The mask register sits at offset 0x10010, and bits [N-1:0] can be read back. A 1 in bit n forces request n low and does not change status bit n.
- R8: Request n is an active-high level equal to status bit n when mask bit n is 0.
- R9: A read of an unmapped offset returns 0. Read data is 0 whenever no read is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 8 | External interrupt pins, asynchronous |
| reg_valid_i | input | 1 | Register access presented this cycle |
| reg_write_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | 20 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as the read |
| irq_req_o | output | 8 | Level-high request per line toward the parent controller |

## Verification
The bench aims at the cycle where a pin edge and a clear write land together. A design that gives the clear priority in that cycle would lose the interrupt, and the read after the write would show 0 instead of 1. It also writes clears to a line in level-low mode: a design that stores the bit in that mode, or that honours the clear, would return 0 while the pin is still low. For every sense code it drives both the matching and the non-matching transitions, which catches swapped rising and falling codes and also a both-edges mode that sees only one edge. Finally, it masks a line that has a pending bit, which exposes a design that clears the status bit instead of only gating the request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_FALL   = 2'd1,
    SENSE_RISE   = 2'd2,
    SENSE_BOTH   = 2'd3
  } sense_e;

  // True when the code latches a pending bit (any edge mode).
  function automatic logic is_edge_mode(input logic [1:0] code);
    return code != SENSE_LVL_LO;
  endfunction

  // Transition detector: previous and current synchronized samples.
  function automatic logic edge_match(input logic [1:0] code,
                                      input logic prev,
                                      input logic cur);
    logic hit;
    unique case (sense_e'(code))
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      SENSE_BOTH: hit = prev ^ cur;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   WIDTH  = 8,
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int DEPTH = STAGES + 1;

  // Stages 0..STAGES-1 synchronize; the last stage keeps one cycle of history.
  logic [DEPTH-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(DEPTH*WIDTH){IDLE}};
    else        pipe_q <= {pipe_q[DEPTH-2:0], pin_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       lvl_i,
  input  logic       prev_i,
  input  logic       clr_i,
  output logic       hit_o,
  output logic       pend_o,
  output logic       view_o
);

  logic pend_q;
  logic edge_md;

  assign edge_md = is_edge_mode(mode_i);
  assign hit_o   = edge_match(mode_i, prev_i, lvl_i);

  // A detected edge outranks a clear presented in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (!edge_md) pend_q <= 1'b0;
    else               pend_q <= hit_o | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
  assign view_o = edge_md ? pend_q : ~lvl_i;

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs #(
  parameter int          N         = 8,
  parameter int          ADDR_W    = 20,
  parameter int          DATA_W    = 32,
  parameter int unsigned STAT_OFS  = 32'h0000_0010,
  parameter int unsigned SENSE_OFS = 32'h0000_0014,
  parameter int unsigned MASK_OFS  = 32'h0001_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      stat_view_i,
  output logic [2*N-1:0]    sense_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_req_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int SW = 2 * N;

  logic sel_stat, sel_sense, sel_mask, wr_en, rd_en;
  logic [SW-1:0] sense_q;
  logic [N-1:0]  mask_q;
  logic          wdata_unused;

  assign sel_stat  = addr_i == ADDR_W'(STAT_OFS);
  assign sel_sense = addr_i == ADDR_W'(SENSE_OFS);
  assign sel_mask  = addr_i == ADDR_W'(MASK_OFS);
  assign wr_en     = valid_i & write_i;
  assign rd_en     = valid_i & ~write_i;
  assign wdata_unused = ^wdata_i[DATA_W-1:SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (sel_sense) sense_q <= wdata_i[SW-1:0];
      if (sel_mask)  mask_q  <= wdata_i[N-1:0];
    end
  end

  // Write-zero-to-clear: a 0 bit in the write data requests a clear.
  assign clr_req_o = (wr_en && sel_stat) ? ~wdata_i[N-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (sel_stat)       rdata_o[N-1:0]  = stat_view_i;
      else if (sel_sense) rdata_o[SW-1:0] = sense_q;
      else if (sel_mask)  rdata_o[N-1:0]  = mask_q;
    end
  end

  assign sense_o = sense_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/ext_irq_sense_top.sv
module ext_irq_sense_top
  import ext_irq_pkg::*;
#(
  parameter int N       = 8,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_pin_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N-1:0]      irq_req_o
);

  logic [N-1:0]   sync_lvl, sync_prev;
  logic [2*N-1:0] sense_q;
  logic [N-1:0]   mask_q, clr_req, clr_ok, edge_mode;
  logic [N-1:0]   edge_hit, pend_q, stat_view;

  ext_irq_sync #(.WIDTH(N), .STAGES(SYNC_ST), .IDLE(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (irq_pin_i),
    .lvl_o  (sync_lvl),
    .prev_o (sync_prev)
  );

  ext_irq_regs #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (reg_valid_i),
    .write_i     (reg_write_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .stat_view_i (stat_view),
    .sense_o     (sense_q),
    .mask_o      (mask_q),
    .clr_req_o   (clr_req),
    .rdata_o     (reg_rdata_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    assign edge_mode[i] = is_edge_mode(sense_q[2*i +: 2]);
    assign clr_ok[i]    = clr_req[i] & edge_mode[i];

    ext_irq_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (sense_q[2*i +: 2]),
      .lvl_i  (sync_lvl[i]),
      .prev_i (sync_prev[i]),
      .clr_i  (clr_ok[i]),
      .hit_o  (edge_hit[i]),
      .pend_o (pend_q[i]),
      .view_o (stat_view[i])
    );
  end

  assign irq_req_o = stat_view & ~mask_q;

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_req_o,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] clr_ok,
  input logic [N-1:0] edge_mode
);

  // R3 and R6: every detected edge is latched, even against a clear.
  p_edge_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));

  // R5: an accepted clear without a concurrent edge drops the bit.
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_ok & ~edge_hit) != '0) |=> ((pend_q & $past(clr_ok & ~edge_hit)) == '0));

  // R4: lines in level-low mode store nothing.
  p_level_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode != '1) |=> ((pend_q & ~$past(edge_mode)) == '0));

  // R7: a masked line never requests.
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req_o & mask_q) == '0));

endmodule

bind ext_irq_sense_top ext_irq_sense_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req_o (irq_req_o),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .edge_hit  (edge_hit),
  .clr_ok    (clr_ok),
  .edge_mode (edge_mode)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_top_tb_top;

  localparam logic [19:0] A_STAT  = 20'h00010;
  localparam logic [19:0] A_SENSE = 20'h00014;
  localparam logic [19:0] A_MASK  = 20'h10010;
  localparam logic [19:0] A_NONE  = 20'h00018;

  typedef struct packed {
    logic [1:0] mode;
    logic       a;
    logic       b;
    logic       exp;
  } vec_t;

  // mode, first pin level, second pin level, expected status after second
  localparam vec_t VEC [16] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0}, '{2'd0, 1'b1, 1'b0, 1'b1},
    '{2'd0, 1'b1, 1'b1, 1'b0}, '{2'd0, 1'b0, 1'b0, 1'b1},
    '{2'd1, 1'b0, 1'b1, 1'b0}, '{2'd1, 1'b1, 1'b0, 1'b1},
    '{2'd1, 1'b1, 1'b1, 1'b0}, '{2'd1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b1, 1'b1}, '{2'd2, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b0}, '{2'd2, 1'b0, 1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b1, 1'b1}, '{2'd3, 1'b1, 1'b0, 1'b1},
    '{2'd3, 1'b1, 1'b1, 1'b0}, '{2'd3, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = 8'hFF;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  req;

  int checks = 0;
  int errors = 0;
  logic [15:0] sense_sh = '0;

  always #4 clk = ~clk;

  ext_irq_sense_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin_i   (pins),
    .reg_valid_i (valid),
    .reg_write_i (write),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_req_o   (req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  // Called at a falling edge; uses no clock cycle.
  task automatic bus_rd(input logic [19:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    bus_rd(A_SENSE, rd); check("R1 sense", rd, 32'h0);
    bus_rd(A_STAT,  rd); check("R1 status", rd, 32'h0);
    bus_rd(A_MASK,  rd); check("R1 mask", rd, 32'h0);
    #1 check("R1 req", {24'h0, req}, 32'h0);
    check("R9 idle rdata", rdata, 32'h0);

    // Vector table: every code against every pin transition
    for (int i = 0; i < 16; i++) begin
      int k = i % 8;
      sense_sh[2*k +: 2] = VEC[i].mode;
      bus_wr(A_SENSE, {16'h0, sense_sh});
      pins[k] = VEC[i].a;
      idle(5);
      bus_wr(A_STAT, ~(32'h1 << k));
      pins[k] = VEC[i].b;
      idle(5);
      bus_rd(A_STAT, rd);
      check(VEC[i].mode == 2'd0 ? "R4 level view" : "R3 edge latch",
            {31'h0, rd[k]}, {31'h0, VEC[i].exp});
      check("R8 req level", {31'h0, req[k]}, {31'h0, VEC[i].exp});
    end

    // R2: sense readback, unused upper bits read 0
    bus_wr(A_SENSE, 32'hFFFF_FFFF);
    bus_rd(A_SENSE, rd); check("R2 sense readback", rd, 32'h0000_FFFF);
    sense_sh = 16'h0;
    bus_wr(A_SENSE, 32'h0);
    pins = 8'hFF;
    idle(5);
    bus_rd(A_NONE, rd); check("R9 unmapped", rd, 32'h0);

    // R4: clear ignored in level-low mode
    pins[6] = 1'b0;
    idle(5);
    bus_wr(A_STAT, 32'hFFFF_FFBF);
    bus_rd(A_STAT, rd); check("R4 clear ignored", {31'h0, rd[6]}, 32'h1);
    pins[6] = 1'b1;
    idle(5);

    // R6: edge and clear in the same cycle; line 2 both edges
    sense_sh[5:4] = 2'd3;
    bus_wr(A_SENSE, {16'h0, sense_sh});
    pins[2] = 1'b0;
    idle(5);
    bus_rd(A_STAT, rd); check("R3 both-edge fall", {31'h0, rd[2]}, 32'h1);
    pins[2] = 1'b1;
    @(negedge clk);
    bus_wr(A_STAT, 32'hFFFF_FFFB);
    bus_rd(A_STAT, rd); check("R6 edge beats clear", {31'h0, rd[2]}, 32'h1);
    bus_wr(A_STAT, 32'hFFFF_FFFB);
    bus_rd(A_STAT, rd); check("R5 clear next cycle", {31'h0, rd[2]}, 32'h0);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    idle(2);

    // R7: mask hides request, status kept; R8 on unmask
    sense_sh[11:10] = 2'd2;
    bus_wr(A_SENSE, {16'h0, sense_sh});
    pins[5] = 1'b0;
    idle(5);
    bus_wr(A_STAT, 32'hFFFF_FFDF);
    pins[5] = 1'b1;
    idle(5);
    bus_wr(A_MASK, 32'hFFFF_FF20);
    bus_rd(A_STAT, rd); check("R7 status kept", {31'h0, rd[5]}, 32'h1);
    #1 check("R7 req masked", {31'h0, req[5]}, 32'h0);
    bus_rd(A_MASK, rd); check("R7 mask readback", rd, 32'h0000_0020);
    bus_wr(A_MASK, 32'h0);
    #1 check("R8 req unmasked", {31'h0, req[5]}, 32'h1);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, rd); check("R5 write one keeps", {31'h0, rd[5]}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule